// File: doc/BRIEF.md
# One-Second Interrupt Status Latch

This block holds the interrupt status bits of a line receiver. There are two groups. The error group takes event sources that count only on their rising edge. The alarm group takes level sources, and each alarm bit can be set to react either to a rising edge or to any change of level. Every status bit latches its event in the cycle the edge is seen. How long the bit then stays set is decided per bit. The deciding inputs are the bit's interrupt enable and the hold-mode control of its group.

A bit with its enable off, or with its group in read mode, keeps its value until a processor read strobe for its group clears it. A bit with its enable on, in a group that is in one-second mode, is timed instead by a one-second tick pulse. In that case it ignores read strobes, and at each tick it clears unless an event was seen during the interval that just ended. A single interrupt line is high whenever any status bit is set while its enable is set. The event sources, the tick generator and the register address decode all sit outside this block.

Top module: `sec_irq_latch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all status bits and `irq` are 0.
- R2: An error status bit sets at the clock edge where its source is first sampled high. A source that stays high does not set the bit again after a clear, and a falling source sets nothing.
- R3: An alarm bit whose `alm_any_edge` bit is 0 sets on a rising source only. An alarm bit whose `alm_any_edge` bit is 1 sets on both a rising and a falling source.
- R4: A status bit whose enable is 0 stays set until a read strobe of its group, whatever the group's hold mode is. One-second ticks do not clear it.
- R5: A status bit whose enable is 1, in a group whose hold-mode input is 0, stays set until a read strobe of its group. Ticks do not clear it.
- R6: A status bit whose enable is 1, in a group whose hold-mode input is 1, ignores read strobes. It is cleared by a tick if no event was seen for it since the previous tick.
- R7: In one-second mode, a bit whose event was seen during an interval is still set after the tick that closes that interval. It clears at the first later tick that closes an interval with no event.
- R8: An event seen in the same cycle as a clearing read strobe leaves the status bit set.
- R9: `irq` is 1 exactly when some status bit is 1 while its enable bit is 1.
- R10: The error hold-mode input and the read strobe act only on error bits. The alarm hold-mode input and the read strobe act only on alarm bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| err_src | input | ERR_W | Error event sources |
| err_ie | input | ERR_W | Error interrupt enables |
| err_sec_mode | input | 1 | Error group hold mode: 1 = one-second, 0 = until read |
| err_rd_clr | input | 1 | Read strobe that clears the error status |
| alm_src | input | ALM_W | Alarm level sources |
| alm_any_edge | input | ALM_W | Per alarm bit: 1 = any transition, 0 = rising edge |
| alm_ie | input | ALM_W | Alarm interrupt enables |
| alm_sec_mode | input | 1 | Alarm group hold mode: 1 = one-second, 0 = until read |
| alm_rd_clr | input | 1 | Read strobe that clears the alarm status |
| err_stat | output | ERR_W | Error status bits |
| alm_stat | output | ALM_W | Alarm status bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The sources are driven in three ways: as a pulse, as a level held high across a clear, and as a falling edge. Together these tell rising-edge detection apart from level sensing and from any-edge detection. Ticks and read strobes are issued in each combination of enable and hold mode, so that read-timed bits and tick-timed bits can each be shown to ignore the other control. One-second intervals with and without a new event show whether a bit stays set for a full interval or clears early. A read issued in the same cycle as an event, and hold modes that differ between the two groups, expose priority errors and crosstalk between the groups.

// File: rtl/sec_irq_latch_pkg.sv
// Package: types shared by the status latch modules.
// Assumes: nothing beyond IEEE 1800-2017.
package sec_irq_latch_pkg;

    // How a source change becomes an event
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_ANY  = 1'b1
    } edge_kind_e;

    // How long a latched bit is held
    typedef enum logic {
        HOLD_TO_READ = 1'b0,
        HOLD_ONE_SEC = 1'b1
    } hold_kind_e;

endpackage

// File: rtl/sil_edge_detect.sv
// Module: sil_edge_detect
// Turns W source levels into one-cycle event flags. Each bit reacts either
// to a rising edge only, or to any change of level, as chosen by kind_sel.
// When HAS_SEL is 0 the selector is ignored and every bit is rising-edge.
// Assumes: the sources are already synchronous to clk.
module sil_edge_detect
    import sec_irq_latch_pkg::*;
#(
    parameter int W       = 8,
    parameter bit HAS_SEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] kind_sel,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev_q;

    // Keep last-cycle source levels for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (HAS_SEL) begin : g_sel
            edge_kind_e kind;
            // Select the event rule for this bit
            always_comb begin
                kind = edge_kind_e'(kind_sel[i]);
                if (kind == EDGE_ANY) evt[i] = src[i] ^ prev_q[i];
                else                  evt[i] = src[i] & ~prev_q[i];
            end
        end else begin : g_rise
            logic unused_sel;
            // Rising-edge only; the selector is not wired
            always_comb begin
                unused_sel = kind_sel[i];
                evt[i]     = src[i] & ~prev_q[i];
            end
        end
    end

endmodule

// File: rtl/sil_status_bank.sv
// Module: sil_status_bank
// Holds W interrupt status bits of one group. A bit sets on its event. If
// its enable is 1 and the group mode is one-second, it is refreshed at each
// tick from the events seen since the previous tick, and reads are ignored.
// Otherwise it is held until a read strobe clears it. An event wins over a
// read in the same cycle.
// Assumes: tick and rd_clr are single-cycle pulses.
module sil_status_bank
    import sec_irq_latch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] ie,
    input  logic         sec_mode,
    input  logic         tick,
    input  logic         rd_clr,
    output logic [W-1:0] stat
);

    hold_kind_e   grp_hold;
    logic [W-1:0] stat_q;
    logic [W-1:0] seen_q;
    logic [W-1:0] stat_d;
    logic [W-1:0] seen_d;

    // Decode the group hold mode
    always_comb grp_hold = hold_kind_e'(sec_mode);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic timed;
        // Next state of one status bit and its interval-event flag
        always_comb begin
            timed     = ie[i] && (grp_hold == HOLD_ONE_SEC);
            seen_d[i] = tick ? 1'b0 : (seen_q[i] | evt[i]);
            if (timed) begin
                if (tick) stat_d[i] = seen_q[i] | evt[i];
                else      stat_d[i] = stat_q[i] | evt[i];
            end else begin
                stat_d[i] = evt[i] | (stat_q[i] & ~rd_clr);
            end
        end
    end

    // Register status and interval flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            seen_q <= '0;
        end else begin
            stat_q <= stat_d;
            seen_q <= seen_d;
        end
    end

    assign stat = stat_q;

endmodule

// File: rtl/sec_irq_latch.sv
// Module: sec_irq_latch (top)
// Error and alarm interrupt status with per-group hold mode and a combined
// interrupt line. Error sources count on rising edges; alarm sources on a
// rising edge or any change, selected per bit.
// Assumes: sources, enables and strobes are synchronous to clk.
module sec_irq_latch
    import sec_irq_latch_pkg::*;
#(
    parameter int ERR_W = 8,
    parameter int ALM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [ERR_W-1:0] err_src,
    input  logic [ERR_W-1:0] err_ie,
    input  logic             err_sec_mode,
    input  logic             err_rd_clr,
    input  logic [ALM_W-1:0] alm_src,
    input  logic [ALM_W-1:0] alm_any_edge,
    input  logic [ALM_W-1:0] alm_ie,
    input  logic             alm_sec_mode,
    input  logic             alm_rd_clr,
    output logic [ERR_W-1:0] err_stat,
    output logic [ALM_W-1:0] alm_stat,
    output logic             irq
);

    logic [ERR_W-1:0] err_evt;
    logic [ALM_W-1:0] alm_evt;

    sil_edge_detect #(.W(ERR_W), .HAS_SEL(1'b0)) u_err_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (err_src),
        .kind_sel ('0),
        .evt      (err_evt)
    );

    sil_edge_detect #(.W(ALM_W), .HAS_SEL(1'b1)) u_alm_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (alm_src),
        .kind_sel (alm_any_edge),
        .evt      (alm_evt)
    );

    sil_status_bank #(.W(ERR_W)) u_err_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (err_evt),
        .ie       (err_ie),
        .sec_mode (err_sec_mode),
        .tick     (sec_tick),
        .rd_clr   (err_rd_clr),
        .stat     (err_stat)
    );

    sil_status_bank #(.W(ALM_W)) u_alm_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (alm_evt),
        .ie       (alm_ie),
        .sec_mode (alm_sec_mode),
        .tick     (sec_tick),
        .rd_clr   (alm_rd_clr),
        .stat     (alm_stat)
    );

    // Combine enabled status bits into one request
    always_comb irq = (|(err_stat & err_ie)) | (|(alm_stat & alm_ie));

endmodule

// File: rtl/sec_irq_latch_chk.sv
// Module: sec_irq_latch_chk
// Property checker for sec_irq_latch, attached by bind below. It keeps its
// own copy of last-cycle source levels, built from the ports only.
module sec_irq_latch_chk #(
    parameter int ERR_W = 8,
    parameter int ALM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sec_tick,
    input logic [ERR_W-1:0] err_src,
    input logic [ERR_W-1:0] err_ie,
    input logic             err_sec_mode,
    input logic             err_rd_clr,
    input logic [ALM_W-1:0] alm_src,
    input logic [ALM_W-1:0] alm_any_edge,
    input logic [ALM_W-1:0] alm_ie,
    input logic             alm_sec_mode,
    input logic             alm_rd_clr,
    input logic [ERR_W-1:0] err_stat,
    input logic [ALM_W-1:0] alm_stat,
    input logic             irq
);

    logic [ERR_W-1:0] e_prev;
    logic [ALM_W-1:0] a_prev;
    logic [ERR_W-1:0] e_rise;
    logic [ALM_W-1:0] a_evt;
    logic [ERR_W-1:0] e_untimed;

    // Track last source levels from the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_prev <= '0;
            a_prev <= '0;
        end else begin
            e_prev <= err_src;
            a_prev <= alm_src;
        end
    end

    // Events expected from the port-level rules
    always_comb begin
        e_rise    = err_src & ~e_prev;
        a_evt     = (alm_src & ~a_prev) | (alm_any_edge & (alm_src ^ a_prev));
        e_untimed = ~(err_ie & {ERR_W{err_sec_mode}});
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (err_stat == '0 && alm_stat == '0));

    // R2
    err_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_rise != '0) |=> ((err_stat & $past(e_rise)) == $past(e_rise)));

    // R3
    alm_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_evt != '0) |=> ((alm_stat & $past(a_evt)) == $past(a_evt)));

    // R5
    read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_rd_clr |=> (($past(err_stat) & $past(e_untimed) & ~err_stat) == '0));

    // R6
    timed_ignores_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sec_mode && !sec_tick && err_rd_clr)
        |=> (($past(err_stat) & $past(err_ie) & ~err_stat) == '0));

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((e_rise & err_ie) != '0) |=> (irq || err_ie != $past(err_ie)));

endmodule

bind sec_irq_latch sec_irq_latch_chk #(.ERR_W(ERR_W), .ALM_W(ALM_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .err_src      (err_src),
    .err_ie       (err_ie),
    .err_sec_mode (err_sec_mode),
    .err_rd_clr   (err_rd_clr),
    .alm_src      (alm_src),
    .alm_any_edge (alm_any_edge),
    .alm_ie       (alm_ie),
    .alm_sec_mode (alm_sec_mode),
    .alm_rd_clr   (alm_rd_clr),
    .err_stat     (err_stat),
    .alm_stat     (alm_stat),
    .irq          (irq)
);

// File: tb/sec_irq_latch_tb_top.sv
// Directed bench for sec_irq_latch: one task per scenario.
module sec_irq_latch_tb_top;

    localparam int EW = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic [EW-1:0] err_src = '0;
    logic [EW-1:0] err_ie = '0;
    logic          err_sec_mode = 1'b0;
    logic          err_rd_clr = 1'b0;
    logic [AW-1:0] alm_src = '0;
    logic [AW-1:0] alm_any_edge = '0;
    logic [AW-1:0] alm_ie = '0;
    logic          alm_sec_mode = 1'b0;
    logic          alm_rd_clr = 1'b0;
    logic [EW-1:0] err_stat;
    logic [AW-1:0] alm_stat;
    logic          irq;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    sec_irq_latch #(.ERR_W(EW), .ALM_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .err_src(err_src), .err_ie(err_ie), .err_sec_mode(err_sec_mode),
        .err_rd_clr(err_rd_clr), .alm_src(alm_src), .alm_any_edge(alm_any_edge),
        .alm_ie(alm_ie), .alm_sec_mode(alm_sec_mode), .alm_rd_clr(alm_rd_clr),
        .err_stat(err_stat), .alm_stat(alm_stat), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs were set after a falling edge; sample after the next
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
    endtask

    task automatic err_read();
        err_rd_clr = 1'b1; cyc(); err_rd_clr = 1'b0;
    endtask

    task automatic alm_read();
        alm_rd_clr = 1'b1; cyc(); alm_rd_clr = 1'b0;
    endtask

    task automatic do_reset();
        err_src = '0; alm_src = '0; err_ie = '0; alm_ie = '0;
        err_sec_mode = 0; alm_sec_mode = 0; alm_any_edge = '0;
        rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; err_src = '1; alm_src = '1; err_ie = '1; alm_ie = '1;
        cyc(); cyc();
        chk("R1 err_stat in reset", 32'(err_stat), 0);
        chk("R1 irq in reset", 32'(irq), 0);
        err_src = '0; alm_src = '0; rst_n = 1'b1; cyc();
        chk("R1 alm_stat after release", 32'(alm_stat), 0);
    endtask

    task automatic t_err_rise();
        do_reset();
        err_src = 8'h05; cyc();
        chk("R2 rise sets bits", 32'(err_stat), 32'h05);
        err_read();
        chk("R2 held level no re-set", 32'(err_stat), 0);
        err_src = 8'h00; cyc();
        chk("R2 falling source sets nothing", 32'(err_stat), 0);
    endtask

    task automatic t_alm_edges();
        do_reset();
        alm_any_edge = 16'h0002;
        alm_src = 16'h0003; cyc();
        chk("R3 rise sets both kinds", 32'(alm_stat), 32'h3);
        alm_read();
        alm_src = 16'h0000; cyc();
        chk("R3 fall sets any-edge bit only", 32'(alm_stat), 32'h2);
    endtask

    task automatic t_ie_off();
        do_reset();
        err_sec_mode = 1'b1;
        err_src = 8'h10; cyc(); err_src = 8'h00; cyc();
        pulse_tick(); cyc(); pulse_tick();
        chk("R4 disabled bit survives ticks", 32'(err_stat), 32'h10);
        err_read();
        chk("R4 disabled bit cleared by read", 32'(err_stat), 0);
    endtask

    task automatic t_read_mode();
        do_reset();
        err_ie = 8'h01;
        err_src = 8'h01; cyc(); err_src = 8'h00; cyc();
        pulse_tick(); pulse_tick();
        chk("R5 read mode ignores ticks", 32'(err_stat), 32'h01);
        err_read();
        chk("R5 read mode cleared by read", 32'(err_stat), 0);
    endtask

    task automatic t_sec_mode();
        do_reset();
        err_ie = 8'h01; err_sec_mode = 1'b1;
        err_src = 8'h01; cyc(); err_src = 8'h00; cyc();
        err_read();
        chk("R6 timed bit ignores read", 32'(err_stat), 32'h01);
        pulse_tick();
        chk("R7 set through closing tick", 32'(err_stat), 32'h01);
        cyc(); cyc();
        pulse_tick();
        chk("R6 cleared by quiet interval", 32'(err_stat), 0);
        err_src = 8'h01; cyc(); err_src = 8'h00; cyc();
        pulse_tick();
        cyc();
        err_src = 8'h01; cyc(); err_src = 8'h00; cyc();
        pulse_tick();
        chk("R7 new event keeps bit", 32'(err_stat), 32'h01);
        pulse_tick();
        chk("R7 clears after quiet interval", 32'(err_stat), 0);
    endtask

    task automatic t_collide();
        do_reset();
        err_src = 8'h01; cyc(); err_src = 8'h00; cyc();
        err_src = 8'h01; err_rd_clr = 1'b1; cyc(); err_rd_clr = 1'b0;
        chk("R8 event beats read", 32'(err_stat), 32'h01);
        alm_src = 16'h0100; alm_rd_clr = 1'b1; cyc(); alm_rd_clr = 1'b0;
        chk("R8 alarm event beats read", 32'(alm_stat), 32'h0100);
    endtask

    task automatic t_irq();
        do_reset();
        alm_src = 16'h8000; cyc();
        chk("R9 irq low when disabled", 32'(irq), 0);
        alm_ie = 16'h8000; #1;
        chk("R9 irq high when enabled", 32'(irq), 1);
        alm_ie = 16'h7fff; #1;
        chk("R9 other enables do not raise irq", 32'(irq), 0);
    endtask

    task automatic t_groups();
        do_reset();
        err_ie = '1; alm_ie = '1; err_sec_mode = 1'b1; alm_sec_mode = 1'b0;
        err_src = 8'h80; alm_src = 16'h0001; cyc();
        err_src = 8'h00; alm_src = 16'h0000; cyc();
        pulse_tick(); pulse_tick();
        chk("R10 error group timed", 32'(err_stat), 0);
        chk("R10 alarm group not timed", 32'(alm_stat), 32'h1);
        err_read();
        chk("R10 error read leaves alarms", 32'(alm_stat), 32'h1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_err_rise();
        t_alm_edges();
        t_ie_off();
        t_read_mode();
        t_sec_mode();
        t_collide();
        t_irq();
        t_groups();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule